// File: doc/BRIEF.md
# Timed Digit Sequence Display Driver

This block plays a fixed string of twelve decimal digits, 0 1 0 4 3 0 0 1 1 0 9 2, on one common-anode seven-segment display, one digit at a time. After the last digit it starts again from the first. A prescaler counts system clock cycles. Every `CLK_HZ` enabled cycles it produces a one-cycle step pulse, so a clock of `CLK_HZ` hertz gives a new digit each second.

A modulo-twelve position counter selects an entry in a stored digit table. A decoder turns that digit into active-low segment drives. The current position is also an output so it can be observed. An enable input freezes the timing and the position without blanking the display. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `digit_seq_display`

## Requirements
- R1: While `rst_n` is low, `pos` is 0 and `seg_n` shows the glyph for digit 0 (7'b1000000).
- R2: With `en` high, `pos` advances by exactly one after every `CLK_HZ` enabled clock cycles, and at no other time.
- R3: Positions 0 to 11 show the digits 0, 1, 0, 4, 3, 0, 0, 1, 1, 0, 9, 2, in that order.
- R4: A step taken from position 11 goes to position 0, so the string repeats.
- R5: `seg_n` bit 6 down to bit 0 drives segments g, f, e, d, c, b, a. A segment is lit when its bit is 0. The glyphs are the usual decimal forms: for example, 1 lights b and c, 4 lights b, c, f and g, and 9 lights a, b, c, d, f and g.
- R6: While `en` is low, `pos`, `seg_n` and the prescaler count all hold. When `en` returns high, the partly counted interval carries on from where it stopped.
- R7: Reset takes effect as soon as `rst_n` goes low. After `rst_n` rises, counting starts on the third rising clock edge.
- R8: `pos` never exceeds 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` hertz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Count enable; low freezes the prescaler and the position |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| pos | output | 4 | Current position in the digit string, 0 to 11 |

## Verification
The bench goes after the wrap from 11 to 0. A counter that let the position run into 12 would blank the display or show a wrong digit instead of restarting the string. It pauses the enable partway through an interval. A design that cleared the prescaler on pause would stretch the next digit, and one that ignored the enable would keep stepping. It also asserts reset in the middle of a cycle and checks the two-edge release delay, which would catch a reset that waits for a clock edge or a release that happens one cycle early or late. Every glyph is compared against segment sets built in the bench, which exposes a swapped segment order or a digit mistyped in the stored string.

// File: rtl/digseq_pkg.sv
package digseq_pkg;

  localparam int SEQ_LEN = 12;
  localparam int POS_W   = $clog2(SEQ_LEN);
  localparam int DIG_W   = 4;
  localparam int SEG_W   = 7;

  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [POS_W-1:0] pos_t;

  // Digit string played by the display, position 0 first.
  localparam digit_t DIGIT_STR [SEQ_LEN] = '{
    4'd0, 4'd1, 4'd0, 4'd4, 4'd3, 4'd0,
    4'd0, 4'd1, 4'd1, 4'd0, 4'd9, 4'd2
  };

  // Drive that leaves every segment dark.
  localparam seg_t SEG_BLANK = '1;

endpackage

// File: rtl/digseq_rst_sync.sv
module digseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= 1'b0;
          else         chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/digseq_prescaler.sv
module digseq_prescaler #(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_term;

  always_comb begin
    at_term = (cnt_q == TERM);
    tick    = en & at_term;
    if (at_term) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/digseq_pos_ctr.sv
module digseq_pos_ctr
  import digseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output pos_t pos
);

  localparam pos_t LAST = POS_W'(SEQ_LEN - 1);

  pos_t pos_q;
  pos_t pos_d;

  always_comb begin
    if (pos_q >= LAST) pos_d = '0;
    else               pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/digseq_digit_rom.sv
module digseq_digit_rom
  import digseq_pkg::*;
(
  input  pos_t   pos,
  output digit_t digit
);

  always_comb begin
    digit = 4'hF;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (pos == POS_W'(i)) digit = DIGIT_STR[i];
    end
  end

endmodule

// File: rtl/digseq_seg_dec.sv
module digseq_seg_dec
  import digseq_pkg::*;
(
  input  digit_t digit,
  output seg_t   seg_n
);

  // Active-low, bit order {g,f,e,d,c,b,a}.
  always_comb begin
    unique case (digit)
      4'd0:    seg_n = 7'b100_0000;
      4'd1:    seg_n = 7'b111_1001;
      4'd2:    seg_n = 7'b010_0100;
      4'd3:    seg_n = 7'b011_0000;
      4'd4:    seg_n = 7'b001_1001;
      4'd5:    seg_n = 7'b001_0010;
      4'd6:    seg_n = 7'b000_0010;
      4'd7:    seg_n = 7'b111_1000;
      4'd8:    seg_n = 7'b000_0000;
      4'd9:    seg_n = 7'b001_0000;
      default: seg_n = SEG_BLANK;
    endcase
  end

endmodule

// File: rtl/digit_seq_display.sv
module digit_seq_display
  import digseq_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic [6:0] seg_n,
  output logic [3:0] pos
);

  logic   rst_int_n;
  logic   tick;
  pos_t   pos_w;
  digit_t digit_w;
  seg_t   seg_w;

  digseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  digseq_prescaler #(.CLK_HZ(CLK_HZ)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (en),
    .tick  (tick)
  );

  digseq_pos_ctr u_pos_ctr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (tick),
    .pos   (pos_w)
  );

  digseq_digit_rom u_rom (
    .pos   (pos_w),
    .digit (digit_w)
  );

  digseq_seg_dec u_dec (
    .digit (digit_w),
    .seg_n (seg_w)
  );

  assign seg_n = seg_w;
  assign pos   = 4'(pos_w);

endmodule

// File: rtl/digit_seq_display_chk.sv
module digit_seq_display_chk #(
  parameter int CLK_HZ = 250_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_int_n,
  input logic       en,
  input logic       tick,
  input logic [6:0] seg_n,
  input logic [3:0] pos
);

  localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) + 1 : 2;

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  since_q <= '0;
    else if (tick)   since_q <= '0;
    else if (en)     since_q <= since_q + 1'b1;
  end

  AST_RESET_HOME: assert property (@(posedge clk) !rst_n |-> (pos == 4'd0 && seg_n == 7'b1000000)); // R1
  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_int_n) tick |-> since_q == CW'(CLK_HZ - 1)); // R2
  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_int_n) tick |=> !$stable(pos)); // R2
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_int_n) !$stable(pos) |-> (pos == $past(pos) + 4'd1 || (pos == 4'd0 && $past(pos) == 4'd11))); // R4
  AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (!rst_int_n) !en |=> $stable(pos)); // R6
  AST_SEG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) $stable(pos) |-> $stable(seg_n)); // R5
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pos <= 4'd11); // R8
  AST_RELEASE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_int_n) |-> pos == 4'd0); // R7

endmodule

bind digit_seq_display digit_seq_display_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .en        (en),
  .tick      (tick),
  .seg_n     (seg_n),
  .pos       (pos)
);

// File: tb/tb_digit_seq_display.sv
`timescale 1ns/1ps
module tb_digit_seq_display;

  localparam int HZ = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b0;
  logic [6:0] seg_n;
  logic [3:0] pos;

  int    checks = 0;
  int    fails  = 0;
  string cur_tag = "R1";
  bit    chk_on = 1'b0;
  bit    done   = 1'b0;

  int m_cnt, m_pos, m_hold, m_prev;

  always #2 clk = ~clk;

  digit_seq_display #(.CLK_HZ(HZ)) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .seg_n (seg_n),
    .pos   (pos)
  );

  function automatic int seq_digit(int p);
    case (p)
      0: return 0;  1: return 1;  2: return 0;  3: return 4;
      4: return 3;  5: return 0;  6: return 0;  7: return 1;
      8: return 1;  9: return 0;  10: return 9; 11: return 2;
      default: return -1;
    endcase
  endfunction

  // Lit segments, bit0 = a ... bit6 = g; the port is the inverse.
  function automatic logic [6:0] lit_set(int d);
    logic [6:0] a = 7'h01, b = 7'h02, c = 7'h04, dd = 7'h08;
    logic [6:0] e = 7'h10, f = 7'h20, g = 7'h40;
    case (d)
      0: return a|b|c|dd|e|f;
      1: return b|c;
      2: return a|b|dd|e|g;
      3: return a|b|c|dd|g;
      4: return b|c|f|g;
      5: return a|c|dd|f|g;
      6: return a|c|dd|e|f|g;
      7: return a|b|c;
      8: return a|b|c|dd|e|f|g;
      9: return a|b|c|dd|f|g;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(int p);
    return ~lit_set(seq_digit(p));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_pos <= 0; m_hold <= 2; m_prev <= 0;
    end else if (m_hold > 0) begin
      m_hold <= m_hold - 1;
    end else if (en) begin
      m_prev <= m_pos;
      if (m_cnt == HZ - 1) begin
        m_cnt <= 0;
        m_pos <= (m_pos == 11) ? 0 : m_pos + 1;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_on && !done) begin
      if (m_prev == 11 && m_pos == 0) check("R4", int'(pos), m_pos);
      else                            check(cur_tag, int'(pos), m_pos);
      check("R3 R5 seg", int'(seg_n), int'(exp_seg(m_pos)));
      check("R8", int'(pos <= 4'd11), 1);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] held_seg;
    logic [3:0] held_pos;
    void'($urandom(32'd4242));
    #1 rst_n = 1'b0;
    @(negedge clk); #1;
    // R1: home state while in reset
    check("R1", int'(pos), 0);
    check("R1", int'(seg_n), int'(7'b1000000));
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    cur_tag = "R7";
    en = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_tag = "R2";
    repeat (2 * 12 * HZ + 7) @(negedge clk);
    // R6: pause partway through an interval
    en = 1'b0;
    @(negedge clk); #1;
    held_pos = pos; held_seg = seg_n;
    cur_tag = "R6";
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); #1;
      check("R6 hold pos", int'(pos), int'(held_pos));
      check("R6 hold seg", int'(seg_n), int'(held_seg));
    end
    en = 1'b1;
    repeat (3 * HZ) @(negedge clk);
    cur_tag = "R2";
    for (int i = 0; i < 1500; i++) begin
      en = ($urandom % 4) != 0;
      @(negedge clk);
    end
    // R7: reset dropped in the middle of a cycle
    en = 1'b1;
    #0.5 rst_n = 1'b0;
    cur_tag = "R7";
    @(negedge clk); #1;
    check("R7 async", int'(pos), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * HZ + 4) @(negedge clk);
    cur_tag = "R2";
    for (int i = 0; i < 1200; i++) begin
      en = ($urandom % 3) != 0;
      @(negedge clk);
    end
    @(negedge clk); #1.5;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule